// File: doc/BRIEF.md
# PWM Auto-Shutdown Controller

This block sits between a PWM generator and its output pin and decides when that output must be forced off. Eight external fault lines feed it, and each line has its own enable bit. A software force bit adds one more request. Any enabled, asserted line, or the force bit, forms a shutdown request. The request latches into an event flag, and while the flag is high the PWM output is held at 0.

The request can act at once, or it can wait for the next period-start strobe of the PWM time base. Waiting keeps a period from being cut short. Recovery is also selectable. In automatic mode the flag drops at the first period start after every request has been gone for at least one cycle. In manual mode the flag stays up until software clears it, and a clear that arrives while a request is still present is ignored. All inputs are synchronous to the block clock.

Top module: `pwm_shutdown_ctrl`

## Requirements
- R1: With `gated_i`=0, an asserted source whose enable bit is 1 makes `evt_flag_o` high and `pwm_o` low in the same cycle.
- R2: Enable bit n (n = 0 to 7, bit 7 highest) qualifies only source line n. A source whose enable bit is 0 never raises a request.
- R3: `force_i`=1 raises a request exactly as an enabled source does, and it obeys `gated_i`.
- R4: With `gated_i`=1, a request raises `evt_flag_o` only in a cycle where `period_strobe_i` is 1 and the request is present. A request that is gone before a strobe never sets the flag.
- R5: With `auto_restart_i`=1, `evt_flag_o` stays high through the cycle of the first strobe that follows at least one cycle with no request, and is low from the next cycle. Without a strobe, the flag stays high.
- R6: A strobe in the same cycle in which the request first goes away does not restart the output. The restart waits for the next strobe.
- R7: With `auto_restart_i`=0, the flag stays high across strobes. A `flag_clr_i` pulse with no request present makes it low from the next cycle.
- R8: `flag_clr_i` has no effect while a request is present, and the flag stays high.
- R9: `pwm_o` equals `pwm_raw_i` while `evt_flag_o` is low, and is 0 while it is high.
- R10: After reset, `evt_flag_o` is 0 and `pwm_o` follows `pwm_raw_i`. A reset applied while the flag is set clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 8 | Shutdown source lines |
| src_en_i | input | 8 | Per-line enable mask, bit n for line n |
| force_i | input | 1 | Software shutdown request |
| gated_i | input | 1 | 1: defer setting the flag to the period strobe |
| auto_restart_i | input | 1 | 1: clear the flag automatically at a period start |
| period_strobe_i | input | 1 | One-cycle period start / rollover pulse |
| flag_clr_i | input | 1 | Software clear of the event flag |
| pwm_raw_i | input | 1 | PWM from the generator |
| pwm_o | output | 1 | PWM after shutdown gating |
| evt_flag_o | output | 1 | Shutdown event flag |

## Verification
The bench walks each mask bit against its own line and against every other bit. A mis-wired mask would leave a source dead, or let a disabled line trip the flag. Three timing cases get their own checks. A strobe that lands in the same cycle the fault drops must not restart the output, or it would come back one period early. A gated request that vanishes before a strobe must leave no trace. A software clear issued while the force bit is still high must be refused, or the output would resume during a fault. A reset issued while the flag is high is checked too, since a flag that survived reset would keep the output dark.

// File: rtl/pwm_shutdown_ctrl.sv
module pwm_shutdown_ctrl #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] src_en_i,
  input  logic            force_i,
  input  logic            gated_i,
  input  logic            auto_restart_i,
  input  logic            period_strobe_i,
  input  logic            flag_clr_i,
  input  logic            pwm_raw_i,
  output logic            pwm_o,
  output logic            evt_flag_o
);

  logic req, req_q, evt_q, set_now, auto_clr, sw_clr;

  assign req      = (|(src_i & src_en_i)) | force_i;
  assign set_now  = req & (~gated_i | period_strobe_i);
  assign auto_clr = auto_restart_i & period_strobe_i & ~req & ~req_q;
  assign sw_clr   = flag_clr_i & ~req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      req_q <= req;
      if (set_now)
        evt_q <= 1'b1;
      else if (auto_clr || sw_clr)
        evt_q <= 1'b0;
    end
  end

  assign evt_flag_o = evt_q | set_now;
  assign pwm_o      = pwm_raw_i & ~evt_flag_o;

endmodule

// File: rtl/pwm_shutdown_ctrl_chk.sv
module pwm_shutdown_ctrl_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic [NSRC-1:0] src_en_i,
  input logic            force_i,
  input logic            gated_i,
  input logic            auto_restart_i,
  input logic            period_strobe_i,
  input logic            flag_clr_i,
  input logic            pwm_raw_i,
  input logic            pwm_o,
  input logic            evt_flag_o
);

  logic any_req;
  assign any_req = (|(src_i & src_en_i)) || force_i;

  AST_IMMEDIATE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!gated_i && any_req) |-> evt_flag_o); // R1
  AST_GATED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_i && !period_strobe_i && !$past(evt_flag_o)) |-> !evt_flag_o); // R4
  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag_o && !auto_restart_i && !flag_clr_i) |=> evt_flag_o); // R7
  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag_o && any_req && flag_clr_i) |=> evt_flag_o); // R8
  AST_OUTPUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flag_o |-> !pwm_o); // R9
  AST_OUTPUT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_flag_o |-> (pwm_o == pwm_raw_i)); // R9

endmodule

bind pwm_shutdown_ctrl pwm_shutdown_ctrl_chk #(.NSRC(NSRC)) u_chk (.*);

// File: tb/pwm_shutdown_ctrl_test.sv
`timescale 1ns/1ps
module pwm_shutdown_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] src = '0, en = '0;
  logic frc = 0, gat = 0, aut = 0, stb = 0, clr = 0, raw = 0;
  logic pwm, flag;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  pwm_shutdown_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .src_en_i(en), .force_i(frc),
    .gated_i(gat), .auto_restart_i(aut), .period_strobe_i(stb),
    .flag_clr_i(clr), .pwm_raw_i(raw), .pwm_o(pwm), .evt_flag_o(flag)
  );

  // {req, src, en, force, gated, auto, strobe, clr, raw, exp_flag, exp_pwm}
  localparam int NV = 28;
  localparam logic [31:0] VEC [NV] = '{
    {4'd9, 8'h00, 8'h00, 6'b000001, 2'b01},  // R9 pass 1
    {4'd9, 8'h00, 8'h00, 6'b000000, 2'b00},  // R9 pass 0
    {4'd2, 8'h01, 8'h00, 6'b000001, 2'b01},  // R2 disabled line
    {4'd2, 8'h01, 8'h02, 6'b000001, 2'b01},  // R2 other bit
    {4'd1, 8'h80, 8'h80, 6'b000001, 2'b10},  // R1 immediate
    {4'd7, 8'h00, 8'h80, 6'b000011, 2'b10},  // R7 clear, visible next
    {4'd7, 8'h00, 8'h80, 6'b000001, 2'b01},  // R7 cleared
    {4'd3, 8'h00, 8'h00, 6'b100001, 2'b10},  // R3 force
    {4'd8, 8'h00, 8'h00, 6'b100011, 2'b10},  // R8 clear refused
    {4'd7, 8'h00, 8'h00, 6'b000101, 2'b10},  // R7 strobe no effect
    {4'd7, 8'h00, 8'h00, 6'b000011, 2'b10},  // R7 clear
    {4'd7, 8'h00, 8'h00, 6'b000001, 2'b01},  // R7
    {4'd4, 8'h04, 8'h04, 6'b010001, 2'b01},  // R4 waits
    {4'd4, 8'h04, 8'h04, 6'b010101, 2'b10},  // R4 sets at strobe
    {4'd6, 8'h00, 8'h04, 6'b011101, 2'b10},  // R6 same-cycle strobe
    {4'd6, 8'h00, 8'h04, 6'b011001, 2'b10},  // R6
    {4'd5, 8'h00, 8'h04, 6'b011101, 2'b10},  // R5 restart strobe
    {4'd5, 8'h00, 8'h04, 6'b011001, 2'b01},  // R5 released
    {4'd1, 8'h10, 8'h10, 6'b001001, 2'b10},  // R1
    {4'd5, 8'h00, 8'h10, 6'b001001, 2'b10},  // R5 no strobe, holds
    {4'd5, 8'h00, 8'h10, 6'b001101, 2'b10},  // R5 strobe
    {4'd5, 8'h00, 8'h10, 6'b001001, 2'b01},  // R5
    {4'd3, 8'h00, 8'h00, 6'b110001, 2'b01},  // R3 gated force waits
    {4'd3, 8'h00, 8'h00, 6'b110101, 2'b10},  // R3 sets at strobe
    {4'd7, 8'h00, 8'h00, 6'b010011, 2'b10},  // R7 clear
    {4'd7, 8'h00, 8'h00, 6'b010001, 2'b01},  // R7
    {4'd4, 8'h02, 8'h02, 6'b010001, 2'b01},  // R4 short request
    {4'd4, 8'h00, 8'h02, 6'b010101, 2'b01}   // R4 gone before strobe
  };

  task automatic check(input int r, input logic ef, input logic ep);
    n_run++;
    if (flag !== ef || pwm !== ep) begin
      n_fail++;
      $display("FAIL R%0d: flag=%b pwm=%b expected flag=%b pwm=%b", r, flag, pwm, ef, ep);
    end
  endtask

  // apply inputs after the falling edge, check, then let the rising edge pass
  task automatic step(input int r, input logic ef, input logic ep);
    #1 check(r, ef, ep);
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    raw = 1'b1;
    repeat (3) @(negedge clk);
    check(10, 1'b0, 1'b1); // R10 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(10, 1'b0, 1'b1); // R10 after reset

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      src = v[23:16]; en = v[15:8];
      {frc, gat, aut, stb, clr, raw} = v[7:2];
      step(int'(v[27:24]), v[1], v[0]);
    end
    {src, en, frc, gat, aut, stb, clr} = '0;
    raw = 1'b1;
    @(negedge clk);

    // R2: each mask bit against its own line and against all others
    for (int b = 0; b < 8; b++) begin
      src = 8'(1 << b); en = ~(8'(1 << b));
      step(2, 1'b0, 1'b1);
      en = 8'(1 << b);
      step(2, 1'b1, 1'b0);
      src = '0; clr = 1'b1;
      step(2, 1'b1, 1'b0);
      clr = 1'b0; en = '0;
      step(2, 1'b0, 1'b1);
    end

    // R10: reset while the flag is set
    frc = 1'b1;
    step(10, 1'b1, 1'b0);
    frc = 1'b0;
    step(10, 1'b1, 1'b0);
    rst_n = 1'b0;
    #1 check(10, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    step(10, 1'b0, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule